// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects 32 level-sensitive interrupt requests and presents them to a processor on two lines: a normal interrupt line and a fast interrupt line. Software makes a request count by enabling it. A request can come from the hardware pin or from a software request bit. Each request is steered to one of the two lines through a routing mask.

Requests on the normal line are ranked through sixteen vector slots. Each slot binds one request number to a handler address, and the slot number is the rank, with slot 0 the strongest. Requests bound to no slot share the weakest rank and the common fallback address. A read of the vector word both fetches the handler address and acknowledges the request. A write to the same word retires the most recently acknowledged rank, so handlers can nest. The fast line is a plain OR and takes no part in vectoring.

Registers sit behind a simple 32-bit read/write port with a 12-bit byte address. There is no wait state, and read data appears one clock after the read request.

Top module: `vic_top`

## Requirements
- R1: An input is active only when its enable bit is set and its pin or its software request is high. A read of 0x000 returns the active inputs routed to the normal line, and a read of 0x004 returns the active inputs routed to the fast line.
- R2: Routing mask 0x00C is read/write, with bit n = 1 sending input n to the fast line. `fiq_o` is the OR of the active fast-routed inputs. Fast-routed inputs are never acknowledged through the vector word.
- R3: A 1 written to 0x010 sets the matching enable bits, and a 1 written to 0x014 clears them. Zero bits leave the enables unchanged. A read of 0x010 returns the enables.
- R4: A 1 written to 0x018 sets the matching software requests, and a 1 written to 0x01C clears them. Zero bits have no effect. A read of 0x018 returns the software requests.
- R5: Slot control 0x200+4n (n = 0..15) holds a source number in bits [4:0] and a slot enable in bit 5, and reads back as written. Writing it with bit 5 set binds that source to slot n. Writing it with bit 5 clear unbinds every source bound to slot n. Handler addresses are at 0x100+4n, the fallback address is at 0x034, and all of them are read/write.
- R6: The rank of a bound input is its slot number, and a lower number wins. An unbound input has rank 16, the weakest, and is served with the fallback address.
- R7: A read of 0x030 returns the handler address of the best-ranked active normal input if that rank beats the rank in service, and marks that rank in service. Otherwise it returns 0 and changes nothing.
- R8: `irq_o` is high exactly when the best active normal input outranks the strongest rank in service. Any active rank counts when nothing is in service.
- R9: Any write to 0x030 retires the strongest rank in service. A write when nothing is in service is ignored.
- R10: Reads of 0xFE0, 0xFE4, 0xFE8 and 0xFEC return 0x90, 0x11, 0x10 and 0x00. Any unimplemented offset reads 0.
- R11: After reset every input is routed to the normal line, disabled, free of software requests and bound to no slot. Nothing is in service, and both outputs are low.
- R12: Pins are sampled on each clock edge. Read data is valid in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin_i | input | 32 | Level-sensitive request pins |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address, low two bits ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
A pin change is captured at the next rising edge. A register write takes effect at the edge that accepts it. So both `irq_o` and `fiq_o` settle right after that single edge, and read data settles after the edge that accepts the read. The bench drives stimulus on falling edges. A behavioural model advances on each rising edge from the same inputs. On every falling edge the bench compares both outputs with the model, and it compares read data in the half cycle after each read edge. The directed checks sample at the same falling edge that ends a bus access.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int unsigned NSRC   = 32;
    localparam int unsigned NSLOT  = 16;
    localparam int unsigned DW     = 32;
    localparam int unsigned AW     = 12;
    localparam int unsigned SRCW   = $clog2(NSRC);
    localparam int unsigned SLOTW  = $clog2(NSLOT);
    localparam int unsigned NLVL   = NSLOT + 1;
    localparam int unsigned LVLW   = $clog2(NLVL + 1);

    typedef logic [LVLW-1:0] lvl_t;

    localparam lvl_t LVL_UNBOUND = lvl_t'(NSLOT);
    localparam lvl_t LVL_NONE    = lvl_t'(NSLOT + 1);

    localparam logic [AW-1:0] A_STAT_N  = 12'h000;
    localparam logic [AW-1:0] A_STAT_F  = 12'h004;
    localparam logic [AW-1:0] A_ROUTE   = 12'h00C;
    localparam logic [AW-1:0] A_EN_SET  = 12'h010;
    localparam logic [AW-1:0] A_EN_CLR  = 12'h014;
    localparam logic [AW-1:0] A_SW_SET  = 12'h018;
    localparam logic [AW-1:0] A_SW_CLR  = 12'h01C;
    localparam logic [AW-1:0] A_VECTOR  = 12'h030;
    localparam logic [AW-1:0] A_FALLBK  = 12'h034;
    localparam logic [AW-1:0] A_ID0     = 12'hFE0;
    localparam logic [AW-1:0] A_ID1     = 12'hFE4;
    localparam logic [AW-1:0] A_ID2     = 12'hFE8;
    localparam logic [AW-1:0] A_ID3     = 12'hFEC;
    localparam logic [5:0]    A_HADDR_PAGE = 6'h04;
    localparam logic [5:0]    A_SCTL_PAGE  = 6'h08;
endpackage

// File: rtl/vic_arb.sv
module vic_arb
    import vic_pkg::*;
(
    input  logic [NSRC-1:0] req_i,
    input  lvl_t [NSRC-1:0] lvl_i,
    output lvl_t            best_o
);
    always_comb begin
        best_o = LVL_NONE;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i] && (lvl_i[i] < best_o)) begin
                best_o = lvl_i[i];
            end
        end
    end
endmodule

// File: rtl/vic_isr.sv
module vic_isr
    import vic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  lvl_t push_lvl_i,
    input  logic pop_i,
    output lvl_t top_o
);
    typedef struct packed {
        logic [NLVL-1:0] busy;
    } isr_st_t;

    isr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop_i) begin
            st_d.busy = st_q.busy & (st_q.busy - NLVL'(1));
        end else if (push_i) begin
            st_d.busy = st_q.busy | (NLVL'(1) << push_lvl_i);
        end
        top_o = LVL_NONE;
        for (int j = NLVL - 1; j >= 0; j--) begin
            if (st_q.busy[j]) top_o = lvl_t'(j);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: an acknowledge only ever stacks a rank stronger than the one in service
    p_push_outranks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (push_lvl_i < top_o));

    // R7: an acknowledge adds exactly one rank in service
    p_push_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> ($countones(st_q.busy) == $countones($past(st_q.busy)) + 1));

    // R9: retiring with nothing in service leaves the in-service set empty
    p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && (st_q.busy == '0)) |=> (st_q.busy == '0));
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_pin_i,
    input  logic            bus_sel_i,
    input  logic            bus_wr_i,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic [DW-1:0]   bus_wdata_i,
    output logic [DW-1:0]   bus_rdata_o,
    output logic            irq_o,
    output logic            fiq_o
);
    typedef struct packed {
        logic [NSRC-1:0]            pin;
        logic [NSRC-1:0]            en;
        logic [NSRC-1:0]            route;
        logic [NSRC-1:0]            sw;
        lvl_t [NSRC-1:0]            lvl;
        logic [NSLOT-1:0][SRCW-1:0] ssrc;
        logic [NSLOT-1:0]           sen;
        logic [NSLOT-1:0][DW-1:0]   haddr;
        logic [DW-1:0]              fallbk;
        logic [DW-1:0]              rdata;
    } vic_st_t;

    vic_st_t st_d, st_q, st_rst;

    logic [NSRC-1:0] active, act_n, act_f;
    logic [AW-1:0]   wa;
    logic [SLOTW-1:0] slot;
    logic            rd_acc, wr_acc, rd_vec, ack, eoi;
    lvl_t            best, top;
    logic [DW-1:0]   vec_val;

    vic_arb u_arb (
        .req_i  (act_n),
        .lvl_i  (st_q.lvl),
        .best_o (best)
    );

    vic_isr u_isr (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (ack),
        .push_lvl_i (best),
        .pop_i      (eoi),
        .top_o      (top)
    );

    always_comb begin
        st_rst = '0;
        for (int i = 0; i < NSRC; i++) st_rst.lvl[i] = LVL_UNBOUND;

        active = st_q.en & (st_q.pin | st_q.sw);
        act_n  = active & ~st_q.route;
        act_f  = active & st_q.route;
        irq_o  = (best < top);
        fiq_o  = |act_f;

        wa     = bus_addr_i & ~AW'(3);
        slot   = wa[SLOTW+1:2];
        rd_acc = bus_sel_i && !bus_wr_i;
        wr_acc = bus_sel_i && bus_wr_i;
        rd_vec = rd_acc && (wa == A_VECTOR);
        ack    = rd_vec && irq_o;
        eoi    = wr_acc && (wa == A_VECTOR);

        if (best < LVL_UNBOUND) vec_val = st_q.haddr[best[SLOTW-1:0]];
        else                    vec_val = st_q.fallbk;

        st_d     = st_q;
        st_d.pin = irq_pin_i;

        if (rd_acc) begin
            st_d.rdata = '0;
            if (wa[AW-1:6] == A_HADDR_PAGE) begin
                st_d.rdata = st_q.haddr[slot];
            end else if (wa[AW-1:6] == A_SCTL_PAGE) begin
                st_d.rdata = DW'({st_q.sen[slot], st_q.ssrc[slot]});
            end else begin
                case (wa)
                    A_STAT_N: st_d.rdata = act_n;
                    A_STAT_F: st_d.rdata = act_f;
                    A_ROUTE:  st_d.rdata = st_q.route;
                    A_EN_SET: st_d.rdata = st_q.en;
                    A_SW_SET: st_d.rdata = st_q.sw;
                    A_VECTOR: st_d.rdata = irq_o ? vec_val : '0;
                    A_FALLBK: st_d.rdata = st_q.fallbk;
                    A_ID0:    st_d.rdata = DW'(8'h90);
                    A_ID1:    st_d.rdata = DW'(8'h11);
                    A_ID2:    st_d.rdata = DW'(8'h10);
                    A_ID3:    st_d.rdata = '0;
                    default:  st_d.rdata = '0;
                endcase
            end
        end

        if (wr_acc) begin
            if (wa[AW-1:6] == A_HADDR_PAGE) begin
                st_d.haddr[slot] = bus_wdata_i;
            end else if (wa[AW-1:6] == A_SCTL_PAGE) begin
                st_d.ssrc[slot] = bus_wdata_i[SRCW-1:0];
                st_d.sen[slot]  = bus_wdata_i[SRCW];
                if (bus_wdata_i[SRCW]) begin
                    st_d.lvl[bus_wdata_i[SRCW-1:0]] = lvl_t'(slot);
                end else begin
                    for (int i = 0; i < NSRC; i++) begin
                        if (st_q.lvl[i] == lvl_t'(slot)) st_d.lvl[i] = LVL_UNBOUND;
                    end
                end
            end else begin
                case (wa)
                    A_ROUTE:  st_d.route  = bus_wdata_i;
                    A_EN_SET: st_d.en     = st_q.en | bus_wdata_i;
                    A_EN_CLR: st_d.en     = st_q.en & ~bus_wdata_i;
                    A_SW_SET: st_d.sw     = st_q.sw | bus_wdata_i;
                    A_SW_CLR: st_d.sw     = st_q.sw & ~bus_wdata_i;
                    A_FALLBK: st_d.fallbk = bus_wdata_i;
                    default:  ;
                endcase
            end
        end

        bus_rdata_o = st_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    // R7: a vector read with nothing to acknowledge returns zero
    p_vec_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && !irq_o) |=> (bus_rdata_o == '0));

    // R3: the set word never drops an enable bit
    p_enset_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && (wa == A_EN_SET)) |=> ((st_q.en & $past(st_q.en)) == $past(st_q.en)));

    // R3: the clear word never raises an enable bit
    p_enclr_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && (wa == A_EN_CLR)) |=> ((st_q.en & ~$past(st_q.en)) == '0));

    // R2: the fast line stays low while no input is routed to it
    p_fiq_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.route == '0) |-> !fiq_o);
endmodule

// File: tb/sim_vic_top.sv
`timescale 1ns/1ps
module sim_vic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_pin = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, fiq;

    int total = 0;
    int bad = 0;
    bit started = 0;

    always #2 clk = ~clk;

    vic_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_pin_i(irq_pin),
        .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_pin, m_en, m_route, m_sw, m_fallbk, m_rdata;
    int        m_lvl[32];
    bit [4:0]  m_ssrc[16];
    bit        m_sen[16];
    bit [31:0] m_haddr[16];
    int        m_stk[$];
    bit        m_rd_pend;
    int        mb, mt;
    bit        mirq;
    bit [11:0] mwa;

    function automatic bit [31:0] m_active();
        return m_en & (m_pin | m_sw);
    endfunction

    function automatic int m_best();
        int b = 17;
        bit [31:0] a = m_active() & ~m_route;
        for (int i = 0; i < 32; i++) if (a[i] && m_lvl[i] < b) b = m_lvl[i];
        return b;
    endfunction

    function automatic int m_top();
        if (m_stk.size() == 0) return 17;
        return m_stk[m_stk.size() - 1];
    endfunction

    task automatic m_reset();
        m_pin = '0; m_en = '0; m_route = '0; m_sw = '0; m_fallbk = '0; m_rdata = '0;
        m_rd_pend = 0;
        for (int i = 0; i < 32; i++) m_lvl[i] = 16;
        for (int n = 0; n < 16; n++) begin m_ssrc[n] = '0; m_sen[n] = 0; m_haddr[n] = '0; end
        m_stk.delete();
    endtask

    function automatic bit [31:0] m_read(bit [11:0] a, int b, bit iv);
        if (a[11:6] == 6'h04) return m_haddr[a[5:2]];
        if (a[11:6] == 6'h08) return {26'd0, m_sen[a[5:2]], m_ssrc[a[5:2]]};
        case (a)
            12'h000: return m_active() & ~m_route;
            12'h004: return m_active() & m_route;
            12'h00C: return m_route;
            12'h010: return m_en;
            12'h018: return m_sw;
            12'h030: return iv ? ((b < 16) ? m_haddr[b] : m_fallbk) : 32'd0;
            12'h034: return m_fallbk;
            12'hFE0: return 32'h90;
            12'hFE4: return 32'h11;
            12'hFE8: return 32'h10;
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_write(bit [11:0] a, bit [31:0] d);
        if (a[11:6] == 6'h04) m_haddr[a[5:2]] = d;
        else if (a[11:6] == 6'h08) begin
            m_ssrc[a[5:2]] = d[4:0];
            m_sen[a[5:2]]  = d[5];
            if (d[5]) m_lvl[d[4:0]] = int'(a[5:2]);
            else for (int i = 0; i < 32; i++) if (m_lvl[i] == int'(a[5:2])) m_lvl[i] = 16;
        end else case (a)
            12'h00C: m_route = d;
            12'h010: m_en = m_en | d;
            12'h014: m_en = m_en & ~d;
            12'h018: m_sw = m_sw | d;
            12'h01C: m_sw = m_sw & ~d;
            12'h030: if (m_stk.size() > 0) void'(m_stk.pop_back());
            12'h034: m_fallbk = d;
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) m_reset();
        else begin
            mb = m_best();
            mt = m_top();
            mirq = (mb < mt);
            mwa = {bus_addr[11:2], 2'b00};
            m_rd_pend = 0;
            if (bus_sel && !bus_wr) begin
                m_rd_pend = 1;
                m_rdata = m_read(mwa, mb, mirq);
                if (mwa == 12'h030 && mirq) m_stk.push_back(mb);
            end
            if (bus_sel && bus_wr) m_write(mwa, bus_wdata);
            m_pin = irq_pin;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (started) begin
            total++;
            if (irq !== (m_best() < m_top())) begin
                bad++;
                $display("FAIL R8 irq_o act=%0b exp=%0b t=%0t", irq, (m_best() < m_top()), $time);
            end
            total++;
            if (fiq !== (|(m_active() & m_route))) begin
                bad++;
                $display("FAIL R2 fiq_o act=%0b exp=%0b t=%0t", fiq, |(m_active() & m_route), $time);
            end
            if (m_rd_pend) begin
                total++;
                if (bus_rdata !== m_rdata) begin
                    bad++;
                    $display("FAIL R12 rdata act=%08h exp=%08h t=%0t", bus_rdata, m_rdata, $time);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%08h exp=%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(logic [11:0] a);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rd_expect(logic [11:0] a, logic [31:0] exp, string tag);
        bus_read(a);
        check(tag, bus_rdata, exp);
    endtask

    task automatic set_pin(int n, bit v);
        @(negedge clk);
        irq_pin[n] = v;
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    logic [31:0] rs = 32'h1234_5678;
    int picks[6] = '{3, 5, 9, 12, 20, 31};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11 reset state
        check("R11 irq_o", {31'd0, irq}, 32'd0);
        check("R11 fiq_o", {31'd0, fiq}, 32'd0);
        rd_expect(12'h00C, 32'd0, "R11 route");
        rd_expect(12'h010, 32'd0, "R11 enable");
        rd_expect(12'h200, 32'd0, "R11 slot ctl");
        rd_expect(12'h030, 32'd0, "R11 vector");

        // R10 identity and unimplemented
        rd_expect(12'hFE0, 32'h90, "R10 id0");
        rd_expect(12'hFE4, 32'h11, "R10 id1");
        rd_expect(12'hFE8, 32'h10, "R10 id2");
        rd_expect(12'hFEC, 32'h00, "R10 id3");
        rd_expect(12'h008, 32'd0, "R10 unimpl 008");
        rd_expect(12'h020, 32'd0, "R10 unimpl 020");
        rd_expect(12'h7F0, 32'd0, "R10 unimpl 7F0");

        // R1 disabled pin stays inactive
        set_pin(3, 1);
        check("R1 disabled irq_o", {31'd0, irq}, 32'd0);
        rd_expect(12'h000, 32'd0, "R1 status disabled");

        // R3 enable set / zero writes
        bus_write(12'h010, 32'h8);
        check("R3 enabled irq_o", {31'd0, irq}, 32'd1);
        bus_write(12'h014, 32'h0);
        check("R3 zero clear irq_o", {31'd0, irq}, 32'd1);
        rd_expect(12'h010, 32'h8, "R3 enable read");
        rd_expect(12'h000, 32'h8, "R1 status normal");

        // R6 fallback address, R7 ack, R9 retire
        bus_write(12'h034, 32'hDEF0_0000);
        rd_expect(12'h030, 32'hDEF0_0000, "R6 fallback vector");
        check("R8 in service low", {31'd0, irq}, 32'd0);
        bus_write(12'h030, 32'd0);
        check("R9 retire irq_o", {31'd0, irq}, 32'd1);

        // R5 slot binding
        bus_write(12'h100, 32'hA000_0000);
        bus_write(12'h108, 32'hA000_0008);
        bus_write(12'h208, 32'h25);
        bus_write(12'h200, 32'h29);
        rd_expect(12'h208, 32'h25, "R5 slot ctl read");
        rd_expect(12'h108, 32'hA000_0008, "R5 handler read");
        bus_write(12'h010, 32'h0000_0220);

        // R6/R7/R8 nesting
        set_pin(3, 0);
        set_pin(5, 1);
        rd_expect(12'h030, 32'hA000_0008, "R6 slot2 vector");
        check("R8 served slot2", {31'd0, irq}, 32'd0);
        set_pin(9, 1);
        check("R8 slot0 preempts", {31'd0, irq}, 32'd1);
        rd_expect(12'h030, 32'hA000_0000, "R7 nested ack");
        check("R8 slot0 served", {31'd0, irq}, 32'd0);
        set_pin(3, 1);
        check("R8 weak rank masked", {31'd0, irq}, 32'd0);
        bus_write(12'h030, 32'd0);
        check("R9 pop to slot2", {31'd0, irq}, 32'd1);
        set_pin(9, 0);
        check("R8 nothing outranks", {31'd0, irq}, 32'd0);
        bus_write(12'h030, 32'd0);
        check("R9 stack empty irq_o", {31'd0, irq}, 32'd1);
        bus_write(12'h030, 32'd0);
        check("R9 empty retire ignored", {31'd0, irq}, 32'd1);
        rd_expect(12'h030, 32'hA000_0008, "R9 after ignored retire");
        bus_write(12'h030, 32'd0);

        // R2 fast routing
        bus_write(12'h00C, 32'h20);
        check("R2 fiq_o", {31'd0, fiq}, 32'd1);
        rd_expect(12'h004, 32'h20, "R1 fast status");
        rd_expect(12'h000, 32'h08, "R1 normal status");
        rd_expect(12'h00C, 32'h20, "R2 route read");
        rd_expect(12'h030, 32'hDEF0_0000, "R2 fast not vectored");
        bus_write(12'h030, 32'd0);

        // R4 software requests
        set_pin(3, 0);
        bus_write(12'h018, 32'h1000);
        bus_write(12'h010, 32'h1000);
        check("R4 soft irq_o", {31'd0, irq}, 32'd1);
        rd_expect(12'h018, 32'h1000, "R4 soft read");
        bus_write(12'h018, 32'h0);
        rd_expect(12'h018, 32'h1000, "R4 zero set no effect");
        bus_write(12'h01C, 32'h1000);
        check("R4 soft cleared", {31'd0, irq}, 32'd0);
        check("R4 fiq kept", {31'd0, fiq}, 32'd1);

        // R5 slot disable unbinds
        set_pin(9, 1);
        check("R5 bound irq_o", {31'd0, irq}, 32'd1);
        bus_write(12'h200, 32'h09);
        rd_expect(12'h030, 32'hDEF0_0000, "R5 unbound uses fallback");
        bus_write(12'h030, 32'd0);
        bus_write(12'h00C, 32'h0);
        irq_pin = '0;

        // random phase compared against the model every cycle
        for (int k = 0; k < 1500; k++) begin
            rs = rs ^ (rs << 13);
            rs = rs ^ (rs >> 17);
            rs = rs ^ (rs << 5);
            case (rs[3:0] % 10)
                0: begin @(negedge clk); irq_pin[picks[rs[10:8] % 6]] ^= 1'b1; end
                1, 2: bus_read(12'h030);
                3: bus_write(12'h030, rs);
                4: bus_write(12'h010, rs & 32'h8010_1228);
                5: bus_write(12'h014, rs & rs >> 7 & 32'h8010_1228);
                6: bus_write(rs[12] ? 12'h018 : 12'h01C, rs & 32'h8010_1228);
                7: bus_write({6'h08, rs[19:16], 2'b00}, {26'd0, rs[20], rs[25:21]});
                8: bus_write(12'h00C, rs & rs >> 9 & 32'h8010_1228);
                default: bus_read(rs[14] ? {6'h04, rs[19:16], 2'b00} : {9'd0, rs[17:15]} << 2);
            endcase
        end

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule